// File: doc/BRIEF.md
# Valid-Tracked Enabled Pipeline

This block is a fixed-latency data pipeline with a one-bit valid pipe running beside it. Each word passes through `LATENCY` register stages. Every stage adds a constant `STEP`, standing in for real arithmetic. One valid bit travels in lockstep with each word, so the consumer can always tell a meaningful output word from filler.

Two inputs combine into one advance condition: a system clock enable and a user enable. While that condition is false, every register holds its value. A synchronous reset empties both pipes and takes priority over the advance condition. The valid input gates the data entering the pipe, so an invalid sample enters as zero and is never treated as a live value.

There is no state machine. The only state is the stage registers: a data word and a valid bit in each stage, all cleared by reset.

Top module: `vp_pipe`

## Requirements
- R1: One clock edge after `rst` is sampled high, `dout` is 0 and `vout` is 0.
- R2: When `rst`, `ce` and `en` are all high at the same edge, reset wins: afterwards `vout` is 0 and `dout` is 0.
- R3: The pipe advances only at an edge where `ce` AND `en` are both 1 and `rst` is 0. At any other edge without reset, `dout` and `vout` keep their values.
- R4: A word presented at an advancing edge reaches `dout` after exactly `LATENCY` advancing edges, with `vout` = 1. Non-advancing edges in between add delay but are not counted.
- R5: For a valid word, `dout` equals `din + LATENCY*STEP`, modulo 2^`DATA_W`.
- R6: A word taken in with `vin` = 0 emerges with `vout` = 0 and `dout` = 0, whatever `din` carried.
- R7: After reset, `vout` stays 0 until the first valid word has travelled the whole pipe, even while the pipe is filling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset; outranks the enables |
| ce | input | 1 | System clock enable |
| en | input | 1 | User enable, ANDed with `ce` |
| din | input | DATA_W | Input data word |
| vin | input | 1 | Input valid flag; gates `din` |
| dout | output | DATA_W | Output data word |
| vout | output | 1 | Output valid flag |

## Verification
The in-line assertions check on every cycle that reset clears the output, that reset outranks a simultaneous enable, that a non-advancing edge changes nothing, that an invalid output carries zero, and that each stage adds exactly `STEP` to a valid word. Some properties cover a whole path rather than one edge: the total latency counted in advancing edges only, the fill-time silence of `vout` after reset, and the end-to-end sum for mixed traffic with random enable gaps. Only the bench's directed and seeded random scenarios show those, by comparing against an independent shift model.

// File: rtl/vp_pkg.sv
package vp_pkg;
    // Advance condition: both enables must be high.
    function automatic logic vp_advance(input logic ce_i, input logic en_i);
        return ce_i & en_i;
    endfunction
endpackage

// File: rtl/vp_entry.sv
module vp_entry #(
    parameter int DATA_W = 16
) (
    input  logic              ce,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    input  logic              vin,
    output logic              adv,
    output logic [DATA_W-1:0] din_gated
);
    import vp_pkg::*;

    always_comb begin
        adv       = vp_advance(ce, en);
        din_gated = din & {DATA_W{vin}};
    end
endmodule

// File: rtl/vp_stage.sv
module vp_stage #(
    parameter int DATA_W = 16,
    parameter int STEP   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [DATA_W-1:0] d_in,
    input  logic              v_in,
    output logic [DATA_W-1:0] d_out,
    output logic              v_out
);
    localparam logic [DATA_W-1:0] STEP_W = DATA_W'(STEP);

    logic [DATA_W-1:0] d_next;

    always_comb begin
        d_next = v_in ? (d_in + STEP_W) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            d_out <= '0;
            v_out <= 1'b0;
        end else if (adv) begin
            d_out <= d_next;
            v_out <= v_in;
        end
    end

    AST_STAGE_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv && v_in) |=> (v_out && d_out == $past(d_in) + STEP_W)); // R5
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(d_out) && $stable(v_out))); // R3
endmodule

// File: rtl/vp_pipe.sv
module vp_pipe #(
    parameter int DATA_W  = 16,
    parameter int LATENCY = 4,
    parameter int STEP    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    input  logic              vin,
    output logic [DATA_W-1:0] dout,
    output logic              vout
);
    localparam int NLINK = LATENCY + 1;

    logic              adv;
    logic [DATA_W-1:0] din_gated;
    logic [DATA_W-1:0] d_link [NLINK];
    logic              v_link [NLINK];

    vp_entry #(.DATA_W(DATA_W)) u_entry (
        .ce(ce), .en(en), .din(din), .vin(vin),
        .adv(adv), .din_gated(din_gated)
    );

    assign d_link[0] = din_gated;
    assign v_link[0] = vin;

    for (genvar s = 0; s < LATENCY; s++) begin : g_stage
        vp_stage #(.DATA_W(DATA_W), .STEP(STEP)) u_stage (
            .clk(clk), .rst(rst), .adv(adv),
            .d_in(d_link[s]), .v_in(v_link[s]),
            .d_out(d_link[s+1]), .v_out(v_link[s+1])
        );
    end

    assign dout = d_link[LATENCY];
    assign vout = v_link[LATENCY];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!vout && dout == '0)); // R1
    AST_RESET_OUTRANKS: assert property (@(posedge clk)
        (rst && ce && en) |=> !vout); // R2
    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(ce && en) |=> ($stable(dout) && $stable(vout))); // R3
    AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
        !vout |-> dout == '0); // R6
endmodule

// File: tb/tb_vp_pipe.sv
module tb_vp_pipe;
    localparam int W   = 16;
    localparam int LAT = 4;
    localparam int STP = 3;
    localparam logic [W-1:0] TOTAL = W'(LAT * STP);

    logic clk = 0;
    logic rst, ce, en, vin;
    logic [W-1:0] din;
    logic [W-1:0] dout;
    logic vout;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] m_d [LAT];
    logic         m_v [LAT];

    vp_pipe #(.DATA_W(W), .LATENCY(LAT), .STEP(STP)) dut (
        .clk(clk), .rst(rst), .ce(ce), .en(en),
        .din(din), .vin(vin), .dout(dout), .vout(vout)
    );

    always #4 clk = ~clk;

    function automatic logic [W-1:0] expect_word(input logic [W-1:0] d, input logic v);
        return v ? d + TOTAL : '0;
    endfunction

    task automatic check(input string req, input logic [W-1:0] ad, input logic av,
                         input logic [W-1:0] ed, input logic ev);
        checks++;
        if (ad !== ed || av !== ev) begin
            errors++;
            $display("FAIL %s: dout=%0h vout=%0b expected dout=%0h vout=%0b", req, ad, av, ed, ev);
        end
    endtask

    task automatic step(input logic r, input logic c, input logic e,
                        input logic [W-1:0] d, input logic v, input string req);
        rst = r; ce = c; en = e; din = d; vin = v;
        @(posedge clk);
        if (r) begin
            for (int i = 0; i < LAT; i++) begin m_d[i] = '0; m_v[i] = 1'b0; end
        end else if (c && e) begin
            for (int i = LAT - 1; i > 0; i--) begin m_d[i] = m_d[i-1]; m_v[i] = m_v[i-1]; end
            m_d[0] = expect_word(d, v);
            m_v[0] = v;
        end
        @(negedge clk);
        check(req, dout, vout, m_d[LAT-1], m_v[LAT-1]);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat_seen;
        void'($urandom(32'd20240611));
        rst = 1; ce = 0; en = 0; din = '0; vin = 0;
        for (int i = 0; i < LAT; i++) begin m_d[i] = '0; m_v[i] = 1'b0; end
        @(negedge clk);
        step(1, 0, 0, 16'h1234, 1, "R1 reset state");
        step(1, 1, 1, 16'hBEEF, 1, "R2 reset beats enable");

        // R7: fill with valid words, vout must stay low for LAT-1 edges
        for (int k = 0; k < LAT + 2; k++)
            step(0, 1, 1, W'(16'h0100 + k), 1, "R7 fill silence");

        // R4: latency of a single valid word
        step(1, 1, 1, '0, 0, "R1 reset");
        lat_seen = 0;
        step(0, 1, 1, 16'h00AA, 1, "R4 latency");
        lat_seen = 1;
        while (!vout && lat_seen < LAT + 3) begin
            step(0, 1, 1, 16'hFFFF, 0, "R6 masked filler");
            lat_seen++;
        end
        checks++;
        if (lat_seen != LAT) begin
            errors++;
            $display("FAIL R4: latency=%0d expected=%0d", lat_seen, LAT);
        end
        check("R5 sum", dout, vout, 16'h00AA + TOTAL, 1'b1);

        // R3: gaps from each enable alone; output must freeze
        step(0, 1, 1, 16'h0011, 1, "R5 load");
        step(0, 0, 1, 16'h5555, 1, "R3 ce low hold");
        step(0, 1, 0, 16'h6666, 1, "R3 en low hold");
        step(0, 0, 0, 16'h7777, 0, "R3 both low hold");

        // R6: invalid words with nonzero data
        for (int k = 0; k < LAT + 1; k++)
            step(0, 1, 1, 16'hFFF0, 0, "R6 invalid masked");

        // R5 wrap-around
        for (int k = 0; k < LAT; k++)
            step(0, 1, 1, 16'hFFFE, 1, "R5 modulo wrap");

        // Random traffic
        for (int k = 0; k < 2000; k++) begin
            logic r;
            r = ($urandom % 64) == 0;
            step(r, ($urandom % 4) != 0, ($urandom % 4) != 0,
                 W'($urandom), ($urandom % 3) != 0, "R3/R5 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule